// File: doc/BRIEF.md
# Multi-Operand Reduction ALU with Status Word

This unit folds a variable-length run of 128-bit operands, popped one by one from a stack, into a single 128-bit result. A command carries an 8-bit opcode and a 64-bit operand count N. The block then takes exactly N operands on a valid/ready stream and reduces them with one of eight operations: unsigned add, subtract or multiply, signed add or subtract, or bitwise AND, OR or XOR.

For the five arithmetic opcodes the block also produces a 128-bit status word. A separate stack receives this word. It reports whether any step of the reduction wrapped. The value is 1 for overflow or for an unsigned borrow, all ones for signed underflow, and 0 when every step was exact. The result is always the low 128 bits of the wrapped computation. The operand that arrives first is the old top of the stack. It is the starting value, and each later operand is applied to the running value in arrival order.

Both inputs are valid/ready streams and obey the same back-pressure rules. A word moves only in a cycle where valid and ready are both high. The sender may raise or drop valid at any time. While valid is high and ready is low, the sender must hold the fields stable. `cmd_ready` is high only while the unit is idle. `opnd_ready` is high only while operands are being collected, and it drops during every multiply step. There is no back-pressure on the result side. `done` is a one-cycle pulse, and the consumer captures `result`, `stat_valid`, `stat_value` and `err` in that cycle.

Top module: `reduce_alu`

## Requirements
- R1: After reset `cmd_ready` is 1 and `opnd_ready`, `done`, `stat_valid` and `err` are 0.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` and `opnd_ready` are never high together. A command offered while an instruction is in progress has no effect on that instruction's result.
- R3: Opcode 0x08 returns the sum of the N operands modulo 2^128. The status is 1 if any partial sum carried out of bit 127, otherwise 0.
- R4: Opcode 0x09 starts from the first operand and subtracts each later operand in arrival order, modulo 2^128. The status is 1 if any step borrowed (subtrahend larger than the running value), otherwise 0.
- R5: Opcode 0x0A returns the product of the N operands modulo 2^128. The status is 1 if any step's full 256-bit product exceeded 128 bits. After each operand beyond the first, `opnd_ready` stays low for 33 cycles (32 radix-16 steps plus one).
- R6: Opcode 0x0C adds the operands as two's-complement values. A step that leaves the positive range gives status 1. A step that leaves the negative range gives status all ones. The first such event in an instruction decides the status, and 0 means none occurred.
- R7: Opcode 0x0D subtracts as in R4 but on two's-complement values, with status coded as in R6.
- R8: Opcodes 0x18, 0x19 and 0x1A reduce the operands with AND, OR and XOR respectively. `stat_valid` stays 0 with their `done`.
- R9: With N = 1 the result equals the single operand. Arithmetic opcodes then report status 0, and `err` is 0.
- R10: With N = 0 no operand is taken. The result is 0 and `err` is 1. Arithmetic opcodes still report status 0 with `stat_valid` high.
- R11: Any opcode outside the eight above is accepted and finishes at once with result 0, `err` 1 and `stat_valid` 0. No operand is taken.
- R12: `done` is high for exactly one cycle. It rises in the cycle after the last operand handshake (N > 0, no pending multiply), after the final multiply step, or after the command handshake (N = 0 or unknown opcode). `stat_valid` and `err` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_op | input | 8 | Opcode |
| cmd_count | input | 64 | Operand count N |
| opnd_valid | input | 1 | Operand offered |
| opnd_ready | output | 1 | Operand can be taken this cycle |
| opnd_data | input | 128 | Operand value |
| done | output | 1 | One-cycle completion pulse |
| result | output | 128 | Reduction result, valid with `done` |
| stat_valid | output | 1 | Status word is to be pushed, with `done` |
| stat_value | output | 128 | Status word: 0, 1 or all ones |
| err | output | 1 | Zero count or unknown opcode, with `done` |

## Verification
The assertions assume that a reset is applied before the first command. They also assume that the command and operand fields carry known values whenever their valid is high and stay stable until the matching ready is seen. The stimulus drives every input to a defined value from time zero and changes inputs only on falling clock edges. It holds each command and operand until the handshake completes. Some runs insert idle cycles between operands, and one run offers a command while the unit is busy. The signed cases are built so that overflow and underflow happen in the middle of a chain, which tests the first-event rule.

// File: rtl/reduce_pkg.sv
package reduce_pkg;
  localparam logic [7:0] OP_UADD = 8'h08;
  localparam logic [7:0] OP_USUB = 8'h09;
  localparam logic [7:0] OP_UMUL = 8'h0A;
  localparam logic [7:0] OP_SADD = 8'h0C;
  localparam logic [7:0] OP_SSUB = 8'h0D;
  localparam logic [7:0] OP_AND  = 8'h18;
  localparam logic [7:0] OP_OR   = 8'h19;
  localparam logic [7:0] OP_XOR  = 8'h1A;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_MUL, S_FIN} red_state_e;
  typedef enum logic [1:0] {K_NONE, K_POS, K_NEG} stat_kind_e;

  function automatic logic op_is_arith(input logic [7:0] op);
    return (op == OP_UADD) || (op == OP_USUB) || (op == OP_UMUL) ||
           (op == OP_SADD) || (op == OP_SSUB);
  endfunction

  function automatic logic op_is_bitwise(input logic [7:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/reduce_addsub.sv
module reduce_addsub #(
  parameter int DATA_W = 128
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              sgn,
  output logic [DATA_W-1:0] sum,
  output logic              evt_pos,
  output logic              evt_neg
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;
  logic            sa, sb, sr;

  always_comb begin
    if (sub) wide = {1'b0, a} - {1'b0, b};
    else     wide = {1'b0, a} + {1'b0, b};
    sum = wide[MSB:0];
    sa  = a[MSB];
    sb  = b[MSB];
    sr  = wide[MSB];
    evt_pos = 1'b0;
    evt_neg = 1'b0;
    if (!sgn) begin
      evt_pos = wide[DATA_W];
    end else if (!sub) begin
      evt_pos = !sa && !sb && sr;
      evt_neg = sa && sb && !sr;
    end else begin
      evt_pos = !sa && sb && sr;
      evt_neg = sa && !sb && !sr;
    end
  end

  always_comb begin
    assert_single_event_R6: assert (!(evt_pos && evt_neg));
  end
endmodule

// File: rtl/reduce_mul.sv
module reduce_mul #(
  parameter int DATA_W = 128,
  parameter int RADIX  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic                busy,
  output logic                fin,
  output logic [2*DATA_W-1:0] prod
);
  localparam int STEPS = DATA_W / RADIX;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int PW    = 2 * DATA_W;

  logic [PW-1:0]     a_sh;
  logic [DATA_W-1:0] b_sh;
  logic [CW-1:0]     cnt;
  logic [PW-1:0]     term;

  always_comb begin
    term = '0;
    for (int i = 0; i < RADIX; i++) begin
      if (b_sh[i]) term = term + (a_sh << i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      fin  <= 1'b0;
      cnt  <= '0;
      prod <= '0;
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        prod <= '0;
        a_sh <= {{DATA_W{1'b0}}, a};
        b_sh <= b;
      end else if (busy) begin
        prod <= prod + term;
        a_sh <= a_sh << RADIX;
        b_sh <= b_sh >> RADIX;
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(STEPS - 1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assert_mul_fin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !busy && $past(busy));
  assert_mul_nostart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/reduce_alu.sv
module reduce_alu #(
  parameter int DATA_W    = 128,
  parameter int CNT_W     = 64,
  parameter int MUL_RADIX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              opnd_valid,
  output logic              opnd_ready,
  input  logic [DATA_W-1:0] opnd_data,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              stat_valid,
  output logic [DATA_W-1:0] stat_value,
  output logic              err
);
  import reduce_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  red_state_e        state_q;
  stat_kind_e        kind_q;
  logic [7:0]        op_q;
  logic [CNT_W-1:0]  rem_q;
  logic [DATA_W-1:0] acc_q;
  logic              first_q, err_q;

  logic              hs, known;
  logic              as_sub, as_sgn, ev_pos, ev_neg;
  logic [DATA_W-1:0] as_sum, bit_res;
  logic              mul_start, mul_busy, mul_fin;
  logic [2*DATA_W-1:0] mul_prod;

  assign cmd_ready  = (state_q == S_IDLE);
  assign opnd_ready = (state_q == S_RECV);
  assign hs         = opnd_valid && opnd_ready;
  assign known      = op_is_arith(cmd_op) || op_is_bitwise(cmd_op);
  assign as_sub     = (op_q == OP_USUB) || (op_q == OP_SSUB);
  assign as_sgn     = (op_q == OP_SADD) || (op_q == OP_SSUB);
  assign mul_start  = hs && !first_q && (op_q == OP_UMUL);

  reduce_addsub #(.DATA_W(DATA_W)) i_addsub (
    .a(acc_q), .b(opnd_data), .sub(as_sub), .sgn(as_sgn),
    .sum(as_sum), .evt_pos(ev_pos), .evt_neg(ev_neg)
  );

  reduce_mul #(.DATA_W(DATA_W), .RADIX(MUL_RADIX)) i_mul (
    .clk(clk), .rst_n(rst_n), .start(mul_start), .a(acc_q), .b(opnd_data),
    .busy(mul_busy), .fin(mul_fin), .prod(mul_prod)
  );

  always_comb begin
    unique case (op_q)
      OP_AND:  bit_res = acc_q & opnd_data;
      OP_OR:   bit_res = acc_q | opnd_data;
      default: bit_res = acc_q ^ opnd_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      op_q    <= '0;
      rem_q   <= '0;
      acc_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          rem_q   <= cmd_count;
          acc_q   <= '0;
          first_q <= 1'b1;
          kind_q  <= K_NONE;
          err_q   <= !known || (cmd_count == '0);
          state_q <= (!known || (cmd_count == '0)) ? S_FIN : S_RECV;
        end
        S_RECV: if (hs) begin
          rem_q   <= rem_q - ONE;
          first_q <= 1'b0;
          if (first_q) begin
            acc_q <= opnd_data;
          end else if (op_is_bitwise(op_q)) begin
            acc_q <= bit_res;
          end else if (op_q != OP_UMUL) begin
            acc_q <= as_sum;
            if (kind_q == K_NONE) begin
              if (ev_neg)      kind_q <= K_NEG;
              else if (ev_pos) kind_q <= K_POS;
            end
          end
          if (mul_start)          state_q <= S_MUL;
          else if (rem_q == ONE)  state_q <= S_FIN;
        end
        S_MUL: if (mul_fin) begin
          acc_q <= mul_prod[DATA_W-1:0];
          if (kind_q == K_NONE && mul_prod[2*DATA_W-1:DATA_W] != '0) kind_q <= K_POS;
          state_q <= (rem_q == '0) ? S_FIN : S_RECV;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done       = (state_q == S_FIN);
  assign result     = acc_q;
  assign stat_valid = done && op_is_arith(op_q);
  assign err        = done && err_q;
  assign stat_value = (kind_q == K_NEG) ? '1 :
                      (kind_q == K_POS) ? DATA_W'(1) : '0;

  assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && opnd_ready));
  assert_mul_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mul_busy |-> !opnd_ready);
  assert_unsigned_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !as_sgn) |-> (stat_value != '1));
  assert_stat_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_value == '0 || stat_value == DATA_W'(1) || stat_value == '1));
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (result == '0 && (!stat_valid || stat_value == '0)));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_stat_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid || err) |-> done);
endmodule

// File: tb/test_reduce_alu.sv
`timescale 1ns/1ps
module test_reduce_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [7:0]   cmd_op = '0;
  logic [63:0]  cmd_count = '0;
  logic         opnd_valid = 1'b0;
  logic         opnd_ready;
  logic [127:0] opnd_data = '0;
  logic         done, stat_valid, err;
  logic [127:0] result, stat_value;

  int errors = 0;
  int checks = 0;
  logic [127:0] ops [0:7];
  bit gap = 0;
  int stall_max = 0;

  localparam logic [127:0] SMAXV = {1'b0, {127{1'b1}}};
  localparam logic [127:0] SMINV = {1'b1, {127{1'b0}}};
  localparam logic signed [129:0] SMAX = {3'b000, {127{1'b1}}};
  localparam logic signed [129:0] SMIN = {3'b111, {127{1'b0}}};

  always #2 clk = ~clk;

  reduce_alu i_reduce_alu (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_count(cmd_count), .opnd_valid(opnd_valid),
    .opnd_ready(opnd_ready), .opnd_data(opnd_data), .done(done),
    .result(result), .stat_valid(stat_valid), .stat_value(stat_value), .err(err)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit arith(input logic [7:0] op);
    return op == 8'h08 || op == 8'h09 || op == 8'h0A || op == 8'h0C || op == 8'h0D;
  endfunction

  function automatic bit known(input logic [7:0] op);
    return arith(op) || op == 8'h18 || op == 8'h19 || op == 8'h1A;
  endfunction

  function automatic void model(input logic [7:0] op, input int n,
                                output logic [127:0] res, output int kind);
    logic [255:0] w;
    logic signed [129:0] s;
    int ev;
    kind = 0;
    res = (n > 0 && known(op)) ? ops[0] : '0;
    for (int i = 1; i < n; i++) begin
      ev = 0;
      s = '0;
      case (op)
        8'h08: begin w = {128'b0, res} + {128'b0, ops[i]}; if (w[255:128] != 0) ev = 1; res = w[127:0]; end
        8'h09: begin if (ops[i] > res) ev = 1; res = res - ops[i]; end
        8'h0A: begin w = {128'b0, res} * {128'b0, ops[i]}; if (w[255:128] != 0) ev = 1; res = w[127:0]; end
        8'h0C, 8'h0D: begin
          if (op == 8'h0C) s = $signed({{2{res[127]}}, res}) + $signed({{2{ops[i][127]}}, ops[i]});
          else             s = $signed({{2{res[127]}}, res}) - $signed({{2{ops[i][127]}}, ops[i]});
          if (s > SMAX) ev = 1; else if (s < SMIN) ev = 2;
          res = s[127:0];
        end
        8'h18: res = res & ops[i];
        8'h19: res = res | ops[i];
        8'h1A: res = res ^ ops[i];
        default: ;
      endcase
      if (kind == 0) kind = ev;
    end
  endfunction

  task automatic run(input string req, input logic [7:0] op, input int n);
    logic [127:0] er;
    int ek, t, st;
    stall_max = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_count = 64'(n);
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < n && known(op); i++) begin
      if (gap) begin opnd_valid = 0; @(negedge clk); end
      opnd_valid = 1; opnd_data = ops[i]; st = 0;
      while (!opnd_ready) begin st++; @(negedge clk); end
      if (st > stall_max) stall_max = st;
      @(posedge clk);
      @(negedge clk);
    end
    opnd_valid = 0;
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    model(op, n, er, ek);
    chk(req, "done", done, 1);
    chk(req, "result", result, er);
    chk(req, "stat_valid", stat_valid, arith(op));
    if (arith(op))
      chk(req, "stat_value", stat_value, ek == 2 ? '1 : 128'(ek));
    chk(req, "err", err, (n == 0) || !known(op));
    @(negedge clk);
    chk("R12", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1", "cmd_ready", cmd_ready, 1);
    chk("R1", "opnd_ready", opnd_ready, 0);
    chk("R1", "done", done, 0);
    chk("R1", "stat_valid", stat_valid, 0);
    chk("R1", "err", err, 0);
  endtask

  task automatic t_uadd;
    ops[0] = 128'd1000; ops[1] = 128'd234; ops[2] = 128'd5;
    run("R3", 8'h08, 3);
    gap = 1;
    ops[0] = '1; ops[1] = 128'd2; ops[2] = 128'd5;
    run("R3", 8'h08, 3);
    gap = 0;
  endtask

  task automatic t_usub;
    ops[0] = 128'd100; ops[1] = 128'd30; ops[2] = 128'd7;
    run("R4", 8'h09, 3);
    ops[0] = 128'd5; ops[1] = 128'd7; ops[2] = 128'd0;
    run("R4", 8'h09, 3);
  endtask

  task automatic t_umul;
    ops[0] = 128'd3; ops[1] = 128'd5; ops[2] = 128'd7;
    run("R5", 8'h0A, 3);
    chk("R5", "stall cycles", 128'(stall_max), 128'd33);
    ops[0] = 128'd1 << 100; ops[1] = 128'd1 << 40; ops[2] = 128'd9;
    run("R5", 8'h0A, 3);
    ops[0] = {64'd0, {64{1'b1}}}; ops[1] = {64'd0, {64{1'b1}}};
    run("R5", 8'h0A, 2);
  endtask

  task automatic t_sadd;
    ops[0] = SMAXV; ops[1] = 128'd1; ops[2] = SMINV; ops[3] = SMINV;
    run("R6", 8'h0C, 4);
    ops[0] = SMINV; ops[1] = '1; ops[2] = 128'd3;
    run("R6", 8'h0C, 3);
    ops[0] = '1; ops[1] = 128'd10; ops[2] = -128'sd4;
    run("R6", 8'h0C, 3);
  endtask

  task automatic t_ssub;
    ops[0] = SMINV; ops[1] = 128'd1;
    run("R7", 8'h0D, 2);
    ops[0] = SMAXV; ops[1] = '1;
    run("R7", 8'h0D, 2);
    ops[0] = 128'd5; ops[1] = 128'd3; ops[2] = 128'd1;
    run("R7", 8'h0D, 3);
  endtask

  task automatic t_bitwise;
    ops[0] = 128'hF0F0_FFFF; ops[1] = 128'h3C3C_00FF; ops[2] = 128'hFFFF_0F0F;
    run("R8", 8'h18, 3);
    run("R8", 8'h19, 3);
    gap = 1;
    run("R8", 8'h1A, 3);
    gap = 0;
  endtask

  task automatic t_single;
    ops[0] = {64'hDEAD_BEEF, 64'h1234};
    run("R9", 8'h08, 1);
    run("R9", 8'h0A, 1);
    run("R9", 8'h0D, 1);
  endtask

  task automatic t_zero;
    run("R10", 8'h08, 0);
    run("R10", 8'h19, 0);
  endtask

  task automatic t_unknown;
    run("R11", 8'h0B, 3);
    chk("R11", "opnd_ready idle", opnd_ready, 0);
  endtask

  task automatic t_busy_cmd;
    int t;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 8'h08; cmd_count = 64'd2;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; opnd_valid = 1; opnd_data = 128'd40;
    @(posedge clk);
    @(negedge clk);
    opnd_valid = 0;
    cmd_valid = 1; cmd_op = 8'h18; cmd_count = 64'd5;
    chk("R2", "cmd_ready busy", cmd_ready, 0);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; opnd_valid = 1; opnd_data = 128'd2;
    @(posedge clk);
    @(negedge clk);
    opnd_valid = 0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk("R2", "result", result, 128'd42);
    @(negedge clk);
    chk("R2", "no extra done", done, 0);
    chk("R2", "idle again", cmd_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_uadd;
    t_usub;
    t_umul;
    t_sadd;
    t_ssub;
    t_bitwise;
    t_single;
    t_zero;
    t_unknown;
    t_busy_cmd;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule